// File: doc/BRIEF.md
# Sleep-Wake Interrupt Controller

This block sits beside a small processor core. It collects interrupt request lines, sorts them through a per-source enable mask, and handles two separate jobs. The first is vectoring: when the global interrupt enable is on, it raises an interrupt-take request carrying the index of the winning source. The second is sleep: after software writes the sleep request, the block stops the core clock and restarts it once any enabled source is pending. Wake depends only on the per-source mask. With the global enable off, the core still wakes, but no vector is taken, so execution carries on at the instruction after the sleep instruction, which was already fetched.

Request lines pass through a two-flop synchronizer. A pending bit is latched on the rising edge of its synchronized line and stays set until software clears it through a write-one-to-clear port, or until the source is taken. Turning on the global enable blocks acceptance for the following cycle, which is one instruction slot. A sleep write placed in that slot therefore always takes effect, even when a request is already waiting. A clear-on-read wake status records which source caused the most recent wake.

Top module: `sleep_wake_intc`

## Requirements
- R1: A rising edge on `irq_in[i]` sets `pend[i]` at the third rising clock edge after the input change. A line that stays high sets the bit only once.
- R2: A cycle with `clr_wr` high clears every `pend` bit whose `clr_wdata` bit is 1, at the next edge. A rising edge arriving in the same cycle wins and keeps the bit set.
- R3: A cycle with `mask_wr` high loads `mask` from `mask_wdata`. A source is active when both its `pend` and `mask` bits are 1. `take_idx` gives the lowest-numbered active source, so source 0 has the highest priority.
- R4: `take_req` is high exactly when all of these hold: `gie` is 1, the previous cycle had no `gie_set`, the block is not asleep, and some source is active. A take clears `gie` and the winner's `pend` bit at the next edge.
- R5: A `gie_set` cycle sets `gie` at the next edge and blocks `take_req` in the cycle after the set. Acceptance resumes one cycle later. `gie_clr` wins over `gie_set`.
- R6: `clk_en` is 1 while awake. It falls in the cycle after a `sleep_wr` cycle and stays 0 while no source is active. A `sleep_wr` that arrives while asleep is ignored.
- R7: While asleep, any active source raises `clk_en` and `wake_pulse` in the same cycle, whatever the state of `gie`. A pending source whose mask bit is 0 does not wake the block.
- R8: `resume` pulses high for one cycle, in the cycle after `wake_pulse`. With `gie` clear at wake, `take_req` stays 0 and the waking `pend` bit stays set. `resume` is never raised by reset.
- R9: At wake, `wake_valid` becomes 1 and `wake_idx` becomes the lowest active source, both at the next edge. A `wake_rd` cycle clears `wake_valid` and `wake_idx` at the next edge, unless a wake happens in that same cycle.
- R10: After reset, `clk_en` is 1 and these outputs are all 0: `pend`, `mask`, `gie`, `take_req`, `wake_pulse`, `resume` and `wake_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Asynchronous interrupt request lines |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | NSRC | Mask value to load |
| clr_wr | input | 1 | Pending clear write strobe |
| clr_wdata | input | NSRC | Write-one-to-clear pending bits |
| gie_set | input | 1 | Set the global interrupt enable |
| gie_clr | input | 1 | Clear the global interrupt enable |
| sleep_wr | input | 1 | Sleep request write strobe |
| wake_rd | input | 1 | Wake status read strobe (clears on read) |
| clk_en | output | 1 | Core clock-gate enable |
| wake_pulse | output | 1 | Single-cycle wake event |
| resume | output | 1 | Core resumes at the prefetched next instruction |
| take_req | output | 1 | Interrupt vector take request |
| take_idx | output | IDXW | Index of the lowest-numbered active source |
| pend | output | NSRC | Pending flags |
| mask | output | NSRC | Per-source enable mask |
| gie | output | 1 | Global interrupt enable state |
| wake_valid | output | 1 | Wake status holds an entry |
| wake_idx | output | IDXW | Source that caused the most recent wake |

## Verification
The priority encoder is swept over every non-zero pending pattern against every mask value, with the global enable off. This separates the masking from the priority order, and it shows that vectoring stays silent without the global enable. Sleep is tried three ways. With only an unmasked source pending, the block must stay asleep. With a masked source and the global enable off, it must wake with no vector taken. With a request already waiting when the global enable is set, the sleep write in the blocked slot must still land. Taking two pending sources in a row checks both the one-slot block after enabling and the automatic clearing of the winner.

// File: rtl/swi_pkg.sv
package swi_pkg;
  // Index of the least significant set bit; 0 when no bit is set.
  function automatic logic [7:0] low_index(input logic [63:0] v);
    logic [7:0] r;
    r = 8'd0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = 8'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/swi_sync_edge.sv
module swi_sync_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/swi_pending.sv
module swi_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_wdata,
  input  logic [N-1:0] take_clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] mask,
  output logic [N-1:0] active
);
  logic [N-1:0] sw_clr;
  logic [N-1:0] pend_n;

  assign sw_clr = clr_wr ? clr_wdata : '0;
  assign pend_n = (pend & ~sw_clr & ~take_clr) | rise;
  assign active = pend & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= pend_n;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R1
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> pend[i]);
    // R2
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_wdata[i] && !rise[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/swi_sleep_ctl.sv
module swi_sleep_ctl
  import swi_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_wr,
  input  logic [N-1:0]  active,
  input  logic          wake_rd,
  output logic          asleep,
  output logic          clk_en,
  output logic          wake_pulse,
  output logic          resume,
  output logic          wake_valid,
  output logic [IW-1:0] wake_idx
);
  logic wake_cond;
  logic [IW-1:0] win_idx;

  assign wake_cond  = asleep & (|active);
  assign win_idx    = IW'(low_index(64'(active)));
  assign clk_en     = ~asleep | wake_cond;
  assign wake_pulse = wake_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      resume     <= 1'b0;
      wake_valid <= 1'b0;
      wake_idx   <= '0;
    end else begin
      resume <= wake_cond;
      if (wake_cond) asleep <= 1'b0;
      else if (sleep_wr && !asleep) asleep <= 1'b1;
      if (wake_cond) begin
        wake_valid <= 1'b1;
        wake_idx   <= win_idx;
      end else if (wake_rd) begin
        wake_valid <= 1'b0;
        wake_idx   <= '0;
      end
    end
  end

  // R6
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_wr && !asleep && !(|active)) |=> !clk_en);
  // R8
  resume_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> (resume && !asleep && !wake_pulse));
  // R9
  wake_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> wake_valid);
endmodule

// File: rtl/swi_vector.sv
module swi_vector
  import swi_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic [N-1:0]  active,
  input  logic          asleep,
  output logic          gie,
  output logic          take_req,
  output logic [IW-1:0] take_idx,
  output logic [N-1:0]  take_clr
);
  logic inhibit;

  assign take_idx = IW'(low_index(64'(active)));
  assign take_req = gie & ~inhibit & ~asleep & (|active);
  assign take_clr = take_req ? (N'(1) << take_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie     <= 1'b0;
      inhibit <= 1'b0;
    end else begin
      inhibit <= gie_set;
      if (gie_clr || take_req) gie <= 1'b0;
      else if (gie_set) gie <= 1'b1;
    end
  end

  // R5
  take_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gie_set) |-> !take_req);
  // R4
  take_gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> !gie);
  // R4
  take_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> !asleep);
endmodule

// File: rtl/sleep_wake_intc.sv
module sleep_wake_intc #(
  parameter int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_wdata,
  input  logic            gie_set,
  input  logic            gie_clr,
  input  logic            sleep_wr,
  input  logic            wake_rd,
  output logic            clk_en,
  output logic            wake_pulse,
  output logic            resume,
  output logic            take_req,
  output logic [IDXW-1:0] take_idx,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] mask,
  output logic            gie,
  output logic            wake_valid,
  output logic [IDXW-1:0] wake_idx
);
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] take_clr;
  logic            asleep;

  swi_sync_edge #(.N(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
  );

  swi_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise(rise),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .take_clr(take_clr),
    .pend(pend), .mask(mask), .active(active)
  );

  swi_sleep_ctl #(.N(NSRC), .IW(IDXW)) u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_wr(sleep_wr), .active(active),
    .wake_rd(wake_rd), .asleep(asleep), .clk_en(clk_en),
    .wake_pulse(wake_pulse), .resume(resume),
    .wake_valid(wake_valid), .wake_idx(wake_idx)
  );

  swi_vector #(.N(NSRC), .IW(IDXW)) u_vec (
    .clk(clk), .rst_n(rst_n), .gie_set(gie_set), .gie_clr(gie_clr),
    .active(active), .asleep(asleep), .gie(gie),
    .take_req(take_req), .take_idx(take_idx), .take_clr(take_clr)
  );

  // R7
  wake_no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && !gie) |=> !take_req);
endmodule

// File: tb/sleep_wake_intc_test.sv
module sleep_wake_intc_test;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, mask_wdata = '0, clr_wdata = '0;
  logic mask_wr = 0, clr_wr = 0, gie_set = 0, gie_clr = 0, sleep_wr = 0, wake_rd = 0;
  logic clk_en, wake_pulse, resume, take_req, gie, wake_valid;
  logic [IW-1:0] take_idx, wake_idx;
  logic [N-1:0] pend, mask;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sleep_wake_intc #(.NSRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .gie_set(gie_set), .gie_clr(gie_clr), .sleep_wr(sleep_wr), .wake_rd(wake_rd),
    .clk_en(clk_en), .wake_pulse(wake_pulse), .resume(resume),
    .take_req(take_req), .take_idx(take_idx), .pend(pend), .mask(mask),
    .gie(gie), .wake_valid(wake_valid), .wake_idx(wake_idx)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Priority reference: scan from the top so the last hit is the lowest bit.
  function automatic int first_src(input logic [N-1:0] v);
    int r = 0;
    for (int k = N - 1; k >= 0; k--) if (v[k]) r = k;
    return r;
  endfunction

  task automatic clear_all();
    clr_wr = 1; clr_wdata = '1;
    tick();
    clr_wr = 0; clr_wdata = '0;
  endtask

  task automatic make_pend(input logic [N-1:0] p);
    irq_in = p;
    tick(3);
    irq_in = '0;
    tick(2);
  endtask

  task automatic set_mask(input logic [N-1:0] m);
    mask_wr = 1; mask_wdata = m;
    tick();
    mask_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 clk_en", clk_en, 1);
    chk("R10 pend", pend, 0);
    chk("R10 mask", mask, 0);
    chk("R10 gie", gie, 0);
    chk("R10 take_req", take_req, 0);
    chk("R10 wake_pulse", wake_pulse, 0);
    chk("R10 resume", resume, 0);
    chk("R10 wake_valid", wake_valid, 0);

    // R1 latency and single set for a held level
    irq_in = 4'b0010;
    tick(2);
    chk("R1 before third edge", pend, 0);
    tick();
    chk("R1 at third edge", pend, 4'b0010);
    clr_wr = 1; clr_wdata = 4'b0010;
    tick();
    clr_wr = 0;
    chk("R2 cleared", pend, 0);
    tick(3);
    chk("R1 held level sets once", pend, 0);
    irq_in = '0;
    tick(2);

    // R2 set wins over clear in the same cycle
    irq_in = 4'b0001;
    tick(2);
    clr_wr = 1; clr_wdata = 4'b0001;
    tick();
    clr_wr = 0;
    chk("R2 set wins", pend, 4'b0001);
    irq_in = '0;
    tick(2);
    clear_all();
    chk("R2 clear all", pend, 0);

    // R3 sweep: every pending pattern against every mask, global enable off
    for (int p = 1; p < 16; p++) begin
      clear_all();
      make_pend(N'(p));
      chk("R1 sweep pend", pend, p);
      for (int m = 0; m < 16; m++) begin
        set_mask(N'(m));
        chk("R3 mask", mask, m);
        if ((p & m) != 0) chk("R3 take_idx", take_idx, first_src(N'(p & m)));
        chk("R8 no vector while gie clear", take_req, 0);
      end
    end

    // R4 / R5 take sequence
    clear_all();
    set_mask(4'b1111);
    make_pend(4'b1100);
    gie_set = 1;
    tick();
    gie_set = 0;
    chk("R5 gie set", gie, 1);
    chk("R5 blocked slot", take_req, 0);
    tick();
    chk("R4 take", take_req, 1);
    chk("R4 take idx", take_idx, 2);
    tick();
    chk("R4 gie cleared", gie, 0);
    chk("R4 winner cleared", pend, 4'b1000);
    chk("R4 no take", take_req, 0);
    gie_set = 1;
    tick();
    gie_set = 0;
    chk("R5 blocked again", take_req, 0);
    tick();
    chk("R4 second take idx", take_idx, 3);
    chk("R4 second take", take_req, 1);
    tick();
    chk("R4 all taken", pend, 0);

    // R5 clear wins, clearing in blocked slot stops take
    make_pend(4'b0001);
    gie_set = 1; gie_clr = 1;
    tick();
    gie_set = 0; gie_clr = 0;
    chk("R5 clr wins", gie, 0);
    gie_set = 1;
    tick();
    gie_set = 0; gie_clr = 1;
    tick();
    gie_clr = 0;
    chk("R5 cleared in slot", gie, 0);
    chk("R4 no take after clr", take_req, 0);
    clear_all();

    // R6 / R7 / R8 / R9 sleep with gie off
    set_mask(4'b0100);
    sleep_wr = 1;
    chk("R6 awake during write", clk_en, 1);
    tick();
    sleep_wr = 0;
    chk("R6 gated", clk_en, 0);
    tick(3);
    chk("R6 stays gated", clk_en, 0);
    irq_in = 4'b0001;
    tick(4);
    irq_in = '0;
    chk("R7 unmasked pend", pend, 4'b0001);
    chk("R7 unmasked no wake", clk_en, 0);
    irq_in = 4'b0100;
    tick(2);
    chk("R7 not yet", clk_en, 0);
    tick();
    chk("R7 clk_en wake", clk_en, 1);
    chk("R7 wake_pulse", wake_pulse, 1);
    chk("R8 resume not yet", resume, 0);
    tick();
    irq_in = '0;
    chk("R8 resume", resume, 1);
    chk("R7 wake pulse single", wake_pulse, 0);
    chk("R8 no take", take_req, 0);
    chk("R9 wake_valid", wake_valid, 1);
    chk("R9 wake_idx", wake_idx, 2);
    tick();
    chk("R8 resume single", resume, 0);
    chk("R8 pend kept", pend, 4'b0101);
    chk("R6 awake", clk_en, 1);
    wake_rd = 1;
    tick();
    wake_rd = 0;
    chk("R9 cleared on read", wake_valid, 0);
    chk("R9 idx cleared", wake_idx, 0);

    // R5 / R6 sleep write in the blocked slot with a request waiting
    clear_all();
    set_mask(4'b1111);
    make_pend(4'b0010);
    gie_set = 1;
    tick();
    gie_set = 0;
    chk("R5 slot no take", take_req, 0);
    sleep_wr = 1;
    tick();
    sleep_wr = 0;
    chk("R6 sleep landed", wake_pulse, 1);
    chk("R4 no take while asleep", take_req, 0);
    tick();
    chk("R4 take after wake", take_req, 1);
    chk("R4 take idx after wake", take_idx, 1);
    chk("R8 resume after wake", resume, 1);
    chk("R9 wake idx", wake_idx, 1);
    tick();
    chk("R4 taken", pend, 0);

    // R8 reset never raises resume
    rst_n = 0;
    tick(2);
    rst_n = 1;
    chk("R8 resume at reset", resume, 0);
    tick();
    chk("R8 resume after reset", resume, 0);
    chk("R10 clk_en after reset", clk_en, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule